// File: doc/BRIEF.md
# Clocked Serial Shift Output Unit

This block is the byte-wide shift register of a bus-attached I/O adapter. It supports one mode only: it sends the byte out serially on the adapter's second control line, at one bit per system clock. A CPU-side strobe marks each read or write of the register. When the auxiliary control mode field holds the shift-out code, that access starts a burst of eight shifts, most significant bit first. Each bit that leaves the top of the register is rotated back into the bottom, so the register holds the same byte again when the burst ends.

When the eighth shift completes, the unit sends a one-cycle set pulse to the interrupt logic and raises its completion flag. The flag sits at bit 2 of the adapter's interrupt flag register. The next access to the shift register clears it. A shift-clock output runs beside the data output. Under any other mode code, the unit releases the serial line, and the manual control-line value passes through unchanged.

Top module: `ser_shift_out`

## Requirements
- R1: Only mode code 3'b110 on `mode_sel` (auxiliary control bits 4:2) enables the unit. Under any other code, `line_own` is 0 and `line_out` equals `man_line`. Under 3'b110, `line_own` is 1.
- R2: In mode 3'b110, an access (`acc_en`=1 for one cycle, with `acc_wr` either 1 or 0) starts a burst of 8 shifts. A write first loads `wr_data` into the register.
- R3: Bits leave most significant first, one per clock. After the k-th rising edge following the access edge (k=1..8), `line_out` shows original bit 8-k.
- R4: Each bit sent is rotated into bit 0. After the 8th shift, `rd_data` equals the byte held before the burst.
- R5: After the burst, `line_out` keeps the last bit sent (original bit 0) until the next shift.
- R6: On the 8th shift, `irq_set` pulses high for exactly one cycle and `sr_flag` becomes 1. In the same cycle, `line_out` equals `rd_data[0]`.
- R7: Any access clears `sr_flag` on the next edge, in any mode. A write outside mode 3'b110 loads the register but does not shift.
- R8: An access during a burst restarts a full 8-shift burst. A write access takes the new byte.
- R9: `sclk_out` is 0 in every cycle in which a shift is still pending, and 1 otherwise.
- R10: Leaving mode 3'b110 during a burst aborts it. No `irq_set` pulse follows and `sr_flag` stays 0.
- R11: After reset, `rd_data` is 0, `sr_flag` and `irq_set` are 0, `sclk_out` is 1, and the held serial bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | One-cycle strobe for a CPU access to the shift register |
| acc_wr | input | 1 | The access is a write (1) or a read (0) |
| wr_data | input | 8 | Byte written by the CPU |
| rd_data | output | 8 | Current register contents for CPU reads |
| mode_sel | input | 3 | Shift-mode field from the auxiliary control register |
| man_line | input | 1 | Manual control-line value from the control-line logic |
| line_out | output | 1 | Serial data line (the second control line) |
| line_own | output | 1 | 1 while the shift unit drives the serial line |
| sclk_out | output | 1 | Shift clock: low while shifts are pending |
| irq_set | output | 1 | One-cycle set pulse for the shift interrupt flag |
| sr_flag | output | 1 | Completion flag (interrupt flag register bit 2) |

## Verification
The assertions check several rules on every cycle:
- an access clears the flag on the next edge;
- the completion pulse lasts exactly one cycle and coincides with a raised flag;
- the bit on the line at completion matches the rotated low bit;
- a released line follows the manual input;
- an owned idle line holds steady.

Some behaviour can only be shown by the bench scenarios:
- the exact serial order of each byte;
- the restored register value;
- a restart partway through a burst;
- an abort when the mode changes;
- the fact that writes outside the mode never shift.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int unsigned MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_SYS_OUT = 3'b110;
   typedef logic [MODE_W-1:0] mode_t;
endpackage

// File: rtl/sr_seq_ctrl.sv
module sr_seq_ctrl #(
   parameter int unsigned N_SHIFTS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic step,
   output logic last
);
   localparam int unsigned CW = $clog2(N_SHIFTS + 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(N_SHIFTS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (start)         cnt_q <= CNT_FULL;
      else if (abort)         cnt_q <= '0;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign step = (cnt_q != '0) && !abort && !start;
   assign last = step && (cnt_q == CW'(1));
endmodule

// File: rtl/sr_data_rot.sv
module sr_data_rot #(
   parameter int unsigned W         = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] q,
   output logic         out_bit
);
   logic [W-1:0] q_r;
   logic [W-1:0] rot;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit = q_r[W-1];
         assign rot     = {q_r[W-2:0], q_r[W-1]};
      end else begin : g_lsb
         assign out_bit = q_r[0];
         assign rot     = {q_r[0], q_r[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_r <= '0;
      else if (load)  q_r <= load_val;
      else if (step)  q_r <= rot;
   end

   assign q = q_r;
endmodule

// File: rtl/sr_line_sel.sv
module sr_line_sel #(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic own,
   input  logic shift_en,
   input  logic bit_in,
   input  logic man_line,
   output logic line_out
);
   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held_q <= IDLE_LEVEL;
      else if (shift_en)  held_q <= bit_in;
   end

   assign line_out = own ? held_q : man_line;
endmodule

// File: rtl/ser_shift_out.sv
module ser_shift_out
   import sr_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter bit          MSB_FIRST = 1'b1,
   parameter bit          IDLE_LEVEL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         acc_en,
   input  logic         acc_wr,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] rd_data,
   input  logic [2:0]   mode_sel,
   input  logic         man_line,
   output logic         line_out,
   output logic         line_own,
   output logic         sclk_out,
   output logic         irq_set,
   output logic         sr_flag
);
   initial begin
      if (W < 2) $error("ser_shift_out: W must be at least 2");
   end

   logic   mode_on;
   logic   start;
   logic   step;
   logic   last;
   logic   out_bit;
   logic   irq_q;
   logic   flag_q;
   logic [W-1:0] data_q;

   assign mode_on  = (mode_t'(mode_sel) == MODE_SYS_OUT);
   assign start    = acc_en && mode_on;

   sr_seq_ctrl #(.N_SHIFTS(W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .abort (!mode_on),
      .step  (step),
      .last  (last)
   );

   sr_data_rot #(.W(W), .MSB_FIRST(MSB_FIRST)) u_rot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc_en && acc_wr),
      .load_val (wr_data),
      .step     (step),
      .q        (data_q),
      .out_bit  (out_bit)
   );

   sr_line_sel #(.IDLE_LEVEL(IDLE_LEVEL)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .own      (mode_on),
      .shift_en (step),
      .bit_in   (out_bit),
      .man_line (man_line),
      .line_out (line_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         irq_q <= last;
         if (acc_en)     flag_q <= 1'b0;
         else if (last)  flag_q <= 1'b1;
      end
   end

   assign rd_data  = data_q;
   assign line_own = mode_on;
   assign sclk_out = !(step || start);
   assign irq_set  = irq_q;
   assign sr_flag  = flag_q;
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
   parameter int unsigned W         = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         acc_en,
   input logic         man_line,
   input logic         line_out,
   input logic         line_own,
   input logic         sclk_out,
   input logic         irq_set,
   input logic         sr_flag,
   input logic [W-1:0] data
);
   logic end_bit;
   assign end_bit = MSB_FIRST ? data[0] : data[W-1];

   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |=> !sr_flag);

   p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> !irq_set);

   p_pulse_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |-> sr_flag);

   p_last_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |-> (line_out == end_bit));

   p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !line_own |-> (line_out == man_line));

   p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_own && sclk_out && !acc_en) |=> (!line_own || $stable(line_out)));
endmodule

bind ser_shift_out sr_checker #(.W(W), .MSB_FIRST(MSB_FIRST)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_en   (acc_en),
   .man_line (man_line),
   .line_out (line_out),
   .line_own (line_own),
   .sclk_out (sclk_out),
   .irq_set  (irq_set),
   .sr_flag  (sr_flag),
   .data     (data_q)
);

// File: tb/sim_ser_shift_out.sv
module sim_ser_shift_out;
   localparam int NV = 6;
   localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_en = 1'b0;
   logic       acc_wr = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [2:0] mode_sel = 3'b000;
   logic       man_line = 1'b0;
   logic       line_out, line_own, sclk_out, irq_set, sr_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ser_shift_out u0 (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .wr_data(wr_data), .rd_data(rd_data), .mode_sel(mode_sel),
      .man_line(man_line), .line_out(line_out), .line_own(line_own),
      .sclk_out(sclk_out), .irq_set(irq_set), .sr_flag(sr_flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [7:0] v);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; wr_data = v;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   // Full burst check; call right after access() returns.
   task automatic burst(input logic [7:0] v, input string tag);
      chk(sclk_out == 1'b0, {tag, " R9 sclk low at start"}, sclk_out, 0);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         chk(line_out == v[8-k], {tag, " R3 bit order"}, line_out, v[8-k]);
         if (k < 8) begin
            chk(sclk_out == 1'b0, {tag, " R9 sclk low mid"}, sclk_out, 0);
            chk(irq_set == 1'b0, {tag, " R6 no early pulse"}, irq_set, 0);
         end
      end
      chk(irq_set == 1'b1, {tag, " R6 pulse"}, irq_set, 1);
      chk(sr_flag == 1'b1, {tag, " R6 flag"}, sr_flag, 1);
      chk(rd_data == v, {tag, " R4 restored"}, rd_data, v);
      chk(sclk_out == 1'b1, {tag, " R9 sclk idle"}, sclk_out, 1);
      @(negedge clk);
      chk(irq_set == 1'b0, {tag, " R6 one cycle"}, irq_set, 0);
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset values
      chk(rd_data == 8'h00, "R11 data", rd_data, 0);
      chk(sr_flag == 1'b0, "R11 flag", sr_flag, 0);
      chk(irq_set == 1'b0, "R11 irq", irq_set, 0);
      chk(sclk_out == 1'b1, "R11 sclk", sclk_out, 1);
      rst_n = 1'b1;
      mode_sel = 3'b110;
      @(negedge clk);
      chk(line_out == 1'b1, "R11 held bit", line_out, 1);
      chk(line_own == 1'b1, "R1 own", line_own, 1);

      // Table walk: write and shift each vector (R2 R3 R4 R6 R9)
      for (int i = 0; i < NV; i++) begin
         access(1'b1, VEC[i]);
         chk(sr_flag == 1'b0, "R7 cleared by write", sr_flag, 0);
         burst(VEC[i], "R2 table");
         repeat (3) @(negedge clk);
         chk(line_out == VEC[i][0], "R5 last bit held", line_out, VEC[i][0]);
      end

      // R2 read access replays the stored byte
      access(1'b0, 8'h00);
      chk(sr_flag == 1'b0, "R7 cleared by read", sr_flag, 0);
      burst(8'h3C, "R2 read");

      // R8 restart in the middle
      access(1'b1, 8'hF0);
      repeat (3) @(negedge clk);
      access(1'b1, 8'h96);
      burst(8'h96, "R8 restart");

      // R10 abort on mode change
      access(1'b1, 8'h5A);
      repeat (3) @(negedge clk);
      mode_sel = 3'b010;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk(irq_set == 1'b0, "R10 no pulse", irq_set, 0);
      end
      chk(sr_flag == 1'b0, "R10 no flag", sr_flag, 0);

      // R1 release: line follows manual input
      man_line = 1'b1;
      @(negedge clk);
      chk(line_out == 1'b1 && line_own == 1'b0, "R1 release hi", line_out, 1);
      man_line = 1'b0;
      @(negedge clk);
      chk(line_out == 1'b0, "R1 release lo", line_out, 0);

      // R7 write outside mode loads but does not shift
      access(1'b1, 8'hC3);
      chk(rd_data == 8'hC3, "R7 load no shift", rd_data, 8'hC3);
      chk(sclk_out == 1'b1, "R7 no shift clock", sclk_out, 1);
      repeat (10) @(negedge clk);
      chk(rd_data == 8'hC3, "R7 still unshifted", rd_data, 8'hC3);
      chk(sr_flag == 1'b0, "R7 no flag", sr_flag, 0);

      // R7 flag set in mode, cleared by access out of mode
      mode_sel = 3'b110;
      access(1'b0, 8'h00);
      burst(8'hC3, "R7 setup");
      mode_sel = 3'b000;
      access(1'b0, 8'h00);
      chk(sr_flag == 1'b0, "R7 clear outside mode", sr_flag, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule